// File: doc/BRIEF.md
# Power-On Reset Sequencer with Relocatable Vectors

This block brings a processor core out of power-on reset. Once power-good rises, it steps through seven timed phases. During the third phase it captures the interrupt-vector base. In the last phase it enables the memory-interface clock, holds that interface in reset for a short time, and then issues the first instruction fetch at the system-reset vector.

After the sequence it arbitrates the two nonmaskable asynchronous exceptions and turns the winner into a fetch address. A system-reset request always wins. A machine-check request is held back only while a system reset is pending. Every vector is the captured base, with its low 20 bits cleared, combined with a fixed offset: 0x100 for system reset and 0x200 for machine check.

Requests that arrive before the sequence ends wait and are served by priority once the core runs. The mode flags show that address translation and caches are off from reset onward.

Top module: `rstseq_top`

## Requirements
- R1: `phase_o` reads 0 while `pwr_good_i` is low. After release it shows phases 0 to 6 in order, each lasting PHASE_CYCLES clock cycles (default 4), and then holds 7 (run). Dropping `pwr_good_i` at any time returns it to 0 at once and restarts the sequence.
- R2: The vector base is taken from `vec_base_i` only on the last cycle of phase 2, with bits 19:0 cleared. Changes to `vec_base_i` at any other time, including during run, do not alter later fetch addresses.
- R3: `mem_clk_en_o` is 0 before phase 6, goes high in the first cycle of phase 6 and stays high. `mem_rst_o` is 1 from reset until 2 cycles after `mem_clk_en_o` rises, then 0.
- R4: In the cycle after `mem_rst_o` falls, `fetch_vld_o` pulses for one cycle with `fetch_addr_o` = base + 0x100 (the boot fetch).
- R5: `xlate_off_o` and `cache_off_o` are 1 in reset and at all times afterwards.
- R6: In run, each cycle in which a system-reset request is pending produces one fetch at base + 0x100, in the cycle after the request was sampled.
- R7: A machine-check request is not taken while a system reset is pending. It produces one fetch at base + 0x200 in the first run cycle with no system reset pending.
- R8: Requests sampled before run are held and served once run begins: system reset in the first run cycle, machine check in the next. Requests sampled while `pwr_good_i` is low are discarded.
- R9: `fetch_vld_o` is never high outside the boot-fetch cycle and run, and each pulse stands for exactly one event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_good_i | input | 1 | Power good; low acts as asynchronous reset |
| vec_base_i | input | 64 | Candidate interrupt-vector base |
| sreset_req_i | input | 1 | System-reset exception request (synchronous pulse or level) |
| mcheck_req_i | input | 1 | Machine-check exception request |
| phase_o | output | 3 | Current phase, 0..6, or 7 for run |
| mem_clk_en_o | output | 1 | Memory-interface clock enable |
| mem_rst_o | output | 1 | Memory-interface reset, active high |
| fetch_addr_o | output | 64 | Fetch / vector address |
| fetch_vld_o | output | 1 | Fetch address valid strobe |
| xlate_off_o | output | 1 | Address translation disabled |
| cache_off_o | output | 1 | Caches disabled |

## Verification
The assertions assume that the exception requests are synchronous to `clk` and that `pwr_good_i` is the only reset, so everything between power-good edges is checked relative to the latest release. They also assume that PHASE_CYCLES is at least the memory-reset hold plus two, so that the boot fetch falls inside phase 6.

The bench changes every input only on falling edges. It moves `vec_base_i` away from the wanted value outside the capture window, and raises requests either before run or in run with idle gaps, so that each expected fetch has a single, computable cycle.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  localparam int ADDR_W      = 64;
  localparam int BASE_ZERO_W = 20;
  localparam int PH_W        = 3;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [PH_W-1:0]   phase_t;

  localparam phase_t PH_BASE = 3'd2;
  localparam phase_t PH_MEM  = 3'd6;
  localparam phase_t PH_RUN  = 3'd7;

  localparam addr_t OFF_SRESET = 64'h100;
  localparam addr_t OFF_MCHECK = 64'h200;

  localparam logic MODE_REAL = 1'b1;

  function automatic addr_t base_mask(input addr_t raw);
    addr_t keep;
    keep = {{(ADDR_W-BASE_ZERO_W){1'b1}}, {BASE_ZERO_W{1'b0}}};
    return raw & keep;
  endfunction

  function automatic addr_t vec_addr(input addr_t base, input addr_t off);
    return base_mask(base) | off;
  endfunction
endpackage

// File: rtl/rstseq_phase_fsm.sv
module rstseq_phase_fsm
  import rstseq_pkg::*;
#(
  parameter int PHASE_CYCLES = 4,
  parameter int MEM_RST_HOLD = 2
) (
  input  logic   clk,
  input  logic   pwr_good,
  output phase_t phase,
  output logic   base_load,
  output logic   in_run,
  output logic   clk_en,
  output logic   mem_rst,
  output logic   boot_fetch
);
  localparam int CNT_W = (PHASE_CYCLES > 2) ? $clog2(PHASE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(PHASE_CYCLES - 1);
  localparam logic [CNT_W-1:0] HOLD_C = CNT_W'(MEM_RST_HOLD);
  localparam logic [CNT_W-1:0] BOOT_C = CNT_W'(MEM_RST_HOLD + 1);

  phase_t           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             phase_last;

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) begin
      phase_q <= '0;
      cnt_q   <= '0;
    end else if (phase_q != PH_RUN) begin
      if (cnt_q == LAST_C) begin
        cnt_q   <= '0;
        phase_q <= phase_q + 3'd1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // Timing events decoded from (phase, count)
  always_comb begin
    phase_last = (phase_q != PH_RUN) && (cnt_q == LAST_C);
    base_load  = (phase_q == PH_BASE) && phase_last;
    in_run     = (phase_q == PH_RUN);
    clk_en     = (phase_q >= PH_MEM);
    mem_rst    = !(in_run || ((phase_q == PH_MEM) && (cnt_q >= HOLD_C)));
    boot_fetch = (phase_q == PH_MEM) && (cnt_q == BOOT_C);
  end

  assign phase = phase_q;

  // R1: phase only advances by one step
  p_phase_step_r1: assert property (@(posedge clk) disable iff (!pwr_good)
    (phase_q != $past(phase_q)) |-> (phase_q == $past(phase_q) + 3'd1));

  // R1: run is sticky until power-good drops
  p_run_sticky_r1: assert property (@(posedge clk) disable iff (!pwr_good)
    (phase_q == PH_RUN) |=> (phase_q == PH_RUN));

  // R3: the interface stays in reset while its clock is off
  p_rst_without_clk_r3: assert property (@(posedge clk) disable iff (!pwr_good)
    !clk_en |-> mem_rst);

  // R3: clock enable never drops after rising
  p_clk_sticky_r3: assert property (@(posedge clk) disable iff (!pwr_good)
    clk_en |=> clk_en);

  // R4: boot fetch follows reset release by one cycle
  p_boot_after_release_r4: assert property (@(posedge clk) disable iff (!pwr_good)
    $fell(mem_rst) |=> boot_fetch);
endmodule

// File: rtl/rstseq_vec_base.sv
module rstseq_vec_base
  import rstseq_pkg::*;
(
  input  logic   clk,
  input  logic   pwr_good,
  input  phase_t phase,
  input  logic   load,
  input  addr_t  base_in,
  output addr_t  base_q
);
  addr_t base_r;

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) base_r <= '0;
    else if (load)  base_r <= base_mask(base_in);
  end

  assign base_q = base_r;

  // R2: the base never moves outside phase 2
  p_base_hold_r2: assert property (@(posedge clk) disable iff (!pwr_good)
    (phase != PH_BASE) |=> $stable(base_r));
endmodule

// File: rtl/rstseq_exc_arb.sv
module rstseq_exc_arb (
  input  logic clk,
  input  logic pwr_good,
  input  logic run,
  input  logic sr_req,
  input  logic mc_req,
  output logic sr_pend,
  output logic mc_pend,
  output logic take_sr,
  output logic take_mc
);
  logic sr_q, mc_q;

  // System reset outranks machine check; both wait for run
  always_comb begin
    take_sr = run && sr_q;
    take_mc = run && mc_q && !sr_q;
  end

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) begin
      sr_q <= 1'b0;
      mc_q <= 1'b0;
    end else begin
      sr_q <= (sr_q && !take_sr) || sr_req;
      mc_q <= (mc_q && !take_mc) || mc_req;
    end
  end

  assign sr_pend = sr_q;
  assign mc_pend = mc_q;

  // R8: pending requests survive until run
  p_sr_held_r8: assert property (@(posedge clk) disable iff (!pwr_good)
    (sr_q && !run) |=> sr_q);
  p_mc_held_r8: assert property (@(posedge clk) disable iff (!pwr_good)
    (mc_q && !run) |=> mc_q);

  // R7: machine check pending survives a system reset pending
  p_mc_deferred_r7: assert property (@(posedge clk) disable iff (!pwr_good)
    (mc_q && sr_q) |=> mc_q);
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int PHASE_CYCLES = 4,
  parameter int MEM_RST_HOLD = 2
) (
  input  logic        clk,
  input  logic        pwr_good_i,
  input  logic [63:0] vec_base_i,
  input  logic        sreset_req_i,
  input  logic        mcheck_req_i,
  output logic [2:0]  phase_o,
  output logic        mem_clk_en_o,
  output logic        mem_rst_o,
  output logic [63:0] fetch_addr_o,
  output logic        fetch_vld_o,
  output logic        xlate_off_o,
  output logic        cache_off_o
);
  phase_t phase;
  logic   base_load, in_run, clk_en, mem_rst, boot_fetch;
  addr_t  base_q;
  logic   sr_pend, mc_pend, take_sr, take_mc;

  rstseq_phase_fsm #(
    .PHASE_CYCLES(PHASE_CYCLES),
    .MEM_RST_HOLD(MEM_RST_HOLD)
  ) u_fsm (
    .clk(clk), .pwr_good(pwr_good_i), .phase(phase), .base_load(base_load),
    .in_run(in_run), .clk_en(clk_en), .mem_rst(mem_rst), .boot_fetch(boot_fetch)
  );

  rstseq_vec_base u_base (
    .clk(clk), .pwr_good(pwr_good_i), .phase(phase), .load(base_load),
    .base_in(vec_base_i), .base_q(base_q)
  );

  rstseq_exc_arb u_arb (
    .clk(clk), .pwr_good(pwr_good_i), .run(in_run),
    .sr_req(sreset_req_i), .mc_req(mcheck_req_i),
    .sr_pend(sr_pend), .mc_pend(mc_pend), .take_sr(take_sr), .take_mc(take_mc)
  );

  always_comb begin
    fetch_vld_o  = boot_fetch || take_sr || take_mc;
    fetch_addr_o = '0;
    if (take_mc)                  fetch_addr_o = vec_addr(base_q, OFF_MCHECK);
    else if (boot_fetch || take_sr) fetch_addr_o = vec_addr(base_q, OFF_SRESET);
  end

  assign phase_o      = phase;
  assign mem_clk_en_o = clk_en;
  assign mem_rst_o    = mem_rst;
  assign xlate_off_o  = MODE_REAL;
  assign cache_off_o  = MODE_REAL;

  // R4: boot fetch targets the system-reset vector
  p_boot_addr_r4: assert property (@(posedge clk) disable iff (!pwr_good_i)
    boot_fetch |-> (fetch_vld_o && fetch_addr_o == vec_addr(base_q, OFF_SRESET)));

  // R6: a pending system reset is served at once in run
  p_sr_served_r6: assert property (@(posedge clk) disable iff (!pwr_good_i)
    (in_run && sr_pend) |-> (fetch_vld_o && fetch_addr_o == vec_addr(base_q, OFF_SRESET)));

  // R7: machine check is served when no system reset waits
  p_mc_served_r7: assert property (@(posedge clk) disable iff (!pwr_good_i)
    (in_run && mc_pend && !sr_pend) |-> (fetch_vld_o && fetch_addr_o == vec_addr(base_q, OFF_MCHECK)));

  // R9: fetch strobe only at boot or in run, one source at a time
  p_fetch_gated_r9: assert property (@(posedge clk) disable iff (!pwr_good_i)
    fetch_vld_o |-> (in_run || boot_fetch));
  p_one_source_r9: assert property (@(posedge clk) disable iff (!pwr_good_i)
    $onehot0({boot_fetch, take_sr, take_mc}));
endmodule

// File: tb/rstseq_top_tb_top.sv
`timescale 1ns/1ps
module rstseq_top_tb_top;
  localparam int P = 4;

  logic        clk = 1'b0;
  logic        pwr_good_i = 1'b0;
  logic [63:0] vec_base_i = '1;
  logic        sreset_req_i = 1'b0;
  logic        mcheck_req_i = 1'b0;
  logic [2:0]  phase_o;
  logic        mem_clk_en_o, mem_rst_o, fetch_vld_o, xlate_off_o, cache_off_o;
  logic [63:0] fetch_addr_o;

  always #4 clk = ~clk;

  rstseq_top #(.PHASE_CYCLES(P), .MEM_RST_HOLD(2)) dut_i (
    .clk(clk), .pwr_good_i(pwr_good_i), .vec_base_i(vec_base_i),
    .sreset_req_i(sreset_req_i), .mcheck_req_i(mcheck_req_i),
    .phase_o(phase_o), .mem_clk_en_o(mem_clk_en_o), .mem_rst_o(mem_rst_o),
    .fetch_addr_o(fetch_addr_o), .fetch_vld_o(fetch_vld_o),
    .xlate_off_o(xlate_off_o), .cache_off_o(cache_off_o)
  );

  typedef struct { logic [63:0] a; string r; } item_t;
  item_t exp_q[$];
  int checks = 0;
  int errors = 0;

  function automatic logic [63:0] expv(input logic [63:0] b, input logic [63:0] off);
    return ((b >> 20) << 20) + off;
  endfunction

  task automatic check(input string r, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  task automatic push(input logic [63:0] a, input string r);
    item_t it;
    it.a = a; it.r = r;
    exp_q.push_back(it);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (fetch_vld_o === 1'b1) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R9 unexpected fetch actual=%h expected=none", fetch_addr_o);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        if (fetch_addr_o !== it.a) begin
          errors++;
          $display("FAIL %s fetch address actual=%h expected=%h", it.r, fetch_addr_o, it.a);
        end
      end
    end
  end

  // Walk a power-up; ncyc cycles after release. base b held only in phase 2.
  task automatic power_up(input logic [63:0] b, input bit early, input int ncyc);
    if (ncyc >= 32) begin
      push(expv(b, 64'h100), "R4");
      if (early) begin
        push(expv(b, 64'h100), "R8");
        push(expv(b, 64'h200), "R8");
      end
    end
    pwr_good_i = 1'b1;
    for (int n = 0; n < ncyc; n++) begin
      vec_base_i   = (n >= 2*P && n < 3*P) ? b : ~b;
      mcheck_req_i = early && (n == 5);
      sreset_req_i = early && (n == 10);
      check("R1", $sformatf("phase n=%0d", n), 64'(phase_o), 64'((n/P > 6) ? 7 : n/P));
      check("R3", $sformatf("clk_en n=%0d", n), 64'(mem_clk_en_o), 64'(n >= 6*P));
      check("R3", $sformatf("mem_rst n=%0d", n), 64'(mem_rst_o), 64'(n < 6*P + 2));
      step();
    end
    vec_base_i   = ~b;
    mcheck_req_i = 1'b0;
    sreset_req_i = 1'b0;
  endtask

  task automatic pulse(input bit sr, input bit mc);
    sreset_req_i = sr;
    mcheck_req_i = mc;
    step();
    sreset_req_i = 1'b0;
    mcheck_req_i = 1'b0;
    repeat (4) step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] b1, b2, b3;
    b1 = 64'h1234_5678_9ABC_DEF0;
    b2 = 64'h0000_00FF_FFF8_1357;
    b3 = 64'hCAFE_0000_0012_3456;

    repeat (3) step();
    // Reset state: R1 R3 R5 R9
    check("R1", "phase in reset", 64'(phase_o), 64'd0);
    check("R3", "clk_en in reset", 64'(mem_clk_en_o), 64'd0);
    check("R3", "mem_rst in reset", 64'(mem_rst_o), 64'd1);
    check("R9", "fetch_vld in reset", 64'(fetch_vld_o), 64'd0);
    check("R5", "xlate_off in reset", 64'(xlate_off_o), 64'd1);
    check("R5", "cache_off in reset", 64'(cache_off_o), 64'd1);

    // Boot with requests raised before run (R1 R2 R3 R4 R8)
    power_up(b1, 1'b1, 32);
    check("R5", "xlate_off in run", 64'(xlate_off_o), 64'd1);
    check("R5", "cache_off in run", 64'(cache_off_o), 64'd1);

    // R6: lone system reset
    push(expv(b1, 64'h100), "R6");
    pulse(1'b1, 1'b0);
    // R7: lone machine check
    push(expv(b1, 64'h200), "R7");
    pulse(1'b0, 1'b1);
    // R7: both together, system reset first
    push(expv(b1, 64'h100), "R7");
    push(expv(b1, 64'h200), "R7");
    pulse(1'b1, 1'b1);
    // R2: base input change in run has no effect
    vec_base_i = 64'hFFFF_0000_FFFF_0000;
    push(expv(b1, 64'h100), "R2");
    pulse(1'b1, 1'b0);
    // R7: system reset held three cycles defers machine check
    for (int k = 0; k < 3; k++) push(expv(b1, 64'h100), "R7");
    push(expv(b1, 64'h200), "R7");
    sreset_req_i = 1'b1;
    mcheck_req_i = 1'b1;
    step();
    mcheck_req_i = 1'b0;
    repeat (2) step();
    sreset_req_i = 1'b0;
    repeat (5) step();
    check("R9", "queue drained after run tests", 64'(exp_q.size()), 64'd0);

    // R1: drop power-good in phase 3 after latching b3
    pwr_good_i = 1'b0;
    step();
    power_up(b3, 1'b0, 14);
    pwr_good_i = 1'b0;
    #1;
    check("R1", "phase after mid drop", 64'(phase_o), 64'd0);
    // R8: requests while power-good low are discarded
    sreset_req_i = 1'b1;
    mcheck_req_i = 1'b1;
    step();
    sreset_req_i = 1'b0;
    mcheck_req_i = 1'b0;
    step();
    check("R1", "phase held low", 64'(phase_o), 64'd0);
    check("R3", "clk_en after drop", 64'(mem_clk_en_o), 64'd0);

    // Restart: R2 new base used for boot vector
    power_up(b2, 1'b0, 32);
    repeat (4) step();
    check("R9", "queue drained at end", 64'(exp_q.size()), 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule